// File: doc/BRIEF.md
# Coherent Line State and Eviction Selector

This block holds the stable coherence state of a small, parameterised set of cache lines and decides which request to send downstream when one of them is evicted. Each cycle it accepts at most one command aimed at one line: a fill, a store, a store-conditional success or failure, an invalidating snoop, or an eviction. A lookup port returns the current state of any line. On an eviction the block reports the downstream request kind, reports no request, or refuses the eviction.

Two configuration inputs shape the behaviour. One allows or forbids the shared-dirty state, which selects MOESI or MESI operation. The other selects home-node behaviour, where dirty data goes straight to memory and clean lines leave silently. Repeated store-conditional failures can place a line into a timed unique-dirty state. In that state the line is pinned against eviction for a fixed number of cycles, which prevents livelock.

Each line runs a small state machine. The states are I (0), SC (1), UC (2), SD (3), UD (4) and UD_T (5). The named transitions are:
- fill-grant: any state to SC, UC, SD or UD.
- store-upgrade: SC, UC, SD or UD to UD.
- snoop-kill: any state to I.
- fail-claim: I to UD or UD_T.
- timeout-release: UD_T to UD.
- evict-drop: any state except UD_T to I.

Top module: `coh_line_evict`

## Requirements
- R1: After reset every line reads I (code 0) on the lookup port, and the three eviction outputs are low.
- R2: A fill command (op 1) with a requested state of SC=1, UC=2, SD=3 or UD=4 sets the line to that state one cycle later. Any other requested value leaves the line unchanged.
- R3: When shared-dirty is disallowed (cfg_allow_sd=0), SD is never produced: a fill requesting SD yields UD instead.
- R4: A store (op 2) or a store-conditional success (op 5) moves SC, UC, SD or UD to UD. It leaves I unchanged, and it leaves UD_T in UD_T.
- R5: An invalidating snoop (op 3) leaves the line in I from any state.
- R6: Each line has a store-conditional failure count, saturating at THRESH+1. A failure (op 4) increments the count. If the line was in I, it moves to UD_T when the new count exceeds THRESH, and to UD otherwise. A failure in any other state leaves that state unchanged.
- R7: The failure count is cleared by a store-conditional success, and by any fill that leaves the line in SC or SD.
- R8: A line stays in UD_T for exactly TOUT cycles after entering it, then reads UD.
- R9: An eviction (op 6) of a line in UD_T sets evict_busy for one cycle, issues no request, and leaves the line in UD_T.
- R10: In normal mode, an eviction issues a request one cycle later with these kinds: 0 full writeback (dirty, no clean sharers); 2 clean writeback (dirty, with clean sharers); 1 write-evict (UC); 3 evict (SC). Dirty means SD or UD.
- R11: In home-node mode (cfg_home=1), evicting a dirty line issues kind 4 (direct memory write), and evicting a clean line issues nothing.
- R12: Evicting a line in I issues nothing. Every accepted eviction leaves the line in I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_allow_sd | input | 1 | 1 = MOESI (SD allowed), 0 = MESI |
| cfg_home | input | 1 | 1 = home-node eviction behaviour |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 fill, 2 store, 3 snoop-invalidate, 4 SC fail, 5 SC ok, 6 evict |
| cmd_line | input | LW | Target line index |
| cmd_fill_st | input | 3 | Requested state for a fill |
| cmd_sharers | input | 1 | Clean sharers exist upstream (for eviction) |
| q_line | input | LW | Lookup index |
| q_state | output | 3 | State of the looked-up line |
| evict_valid | output | 1 | A downstream request is issued |
| evict_kind | output | 3 | Request kind, valid with evict_valid |
| evict_busy | output | 1 | Eviction refused (line pinned) |

## Verification
A wrong state register shows up on the lookup port one cycle after the command that wrote it. It also shows up as a wrong request kind on the next eviction of that line, one cycle after the evict command. Errors in the failure counter stay hidden until the next failure from I lands in the wrong one of UD or UD_T. Errors in the timeout counter show as a UD_T residency that differs from TOUT cycles, or as a busy refusal that appears or disappears where it should not.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [2:0] {
        ST_I   = 3'd0,
        ST_SC  = 3'd1,
        ST_UC  = 3'd2,
        ST_SD  = 3'd3,
        ST_UD  = 3'd4,
        ST_UDT = 3'd5
    } line_st_t;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_FILL   = 3'd1,
        OP_STORE  = 3'd2,
        OP_SNPINV = 3'd3,
        OP_SCFAIL = 3'd4,
        OP_SCOK   = 3'd5,
        OP_EVICT  = 3'd6,
        OP_RSVD   = 3'd7
    } line_op_t;

    typedef enum logic [2:0] {
        RQ_WB_FULL    = 3'd0,
        RQ_WEVICT     = 3'd1,
        RQ_WCLEAN     = 3'd2,
        RQ_EVICT      = 3'd3,
        RQ_MEM_WRITE  = 3'd4
    } evict_rq_t;
endpackage

// File: rtl/coh_line_slot.sv
module coh_line_slot
    import coh_pkg::*;
#(
    parameter int THRESH = 2,
    parameter int TOUT   = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_allow_sd,
    input  logic     hit,
    input  line_op_t op,
    input  logic [2:0] fill_st,
    output line_st_t st
);
    localparam int CMAX = THRESH + 1;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int TW   = $clog2(TOUT + 1);

    line_st_t       st_n;
    logic [CW-1:0]  cnt, cnt_n, cnt_inc;
    logic [TW-1:0]  tmr, tmr_n;

    assign cnt_inc = (cnt == CW'(CMAX)) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_I;
            cnt <= '0;
            tmr <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            tmr <= tmr_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        tmr_n = tmr;
        if (st == ST_UDT) begin
            if (tmr <= TW'(1)) begin
                st_n  = ST_UD;
                tmr_n = '0;
            end else begin
                tmr_n = tmr - 1'b1;
            end
        end
        if (hit) begin
            unique case (op)
                OP_FILL: begin
                    unique case (fill_st)
                        3'd1: begin st_n = ST_SC; cnt_n = '0; end
                        3'd2: st_n = ST_UC;
                        3'd3: begin
                            if (cfg_allow_sd) begin
                                st_n  = ST_SD;
                                cnt_n = '0;
                            end else begin
                                st_n = ST_UD;
                            end
                        end
                        3'd4: st_n = ST_UD;
                        default: ;
                    endcase
                end
                OP_STORE, OP_SCOK: begin
                    if (st != ST_I && st != ST_UDT) st_n = ST_UD;
                    if (op == OP_SCOK) cnt_n = '0;
                end
                OP_SNPINV: st_n = ST_I;
                OP_SCFAIL: begin
                    cnt_n = cnt_inc;
                    if (st == ST_I) begin
                        if (cnt_inc > CW'(THRESH)) begin
                            st_n  = ST_UDT;
                            tmr_n = TW'(TOUT);
                        end else begin
                            st_n = ST_UD;
                        end
                    end
                end
                OP_EVICT: if (st != ST_UDT) st_n = ST_I;
                default: ;
            endcase
        end
        if (st_n != ST_UDT) tmr_n = '0;
    end

    p_no_new_sd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_allow_sd && st != ST_SD) |=> st != ST_SD);
    p_snoop_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_SNPINV) |=> st == ST_I);
    p_pinned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_EVICT && st == ST_UDT && tmr > TW'(1)) |=> st == ST_UDT);
    p_timer_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UDT) |-> tmr != '0);
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_SCOK) |=> cnt == '0);
endmodule

// File: rtl/coh_evict_sel.sv
module coh_evict_sel
    import coh_pkg::*;
(
    input  line_st_t  st,
    input  logic      sharers,
    input  logic      home,
    output logic      issue,
    output evict_rq_t kind
);
    logic dirty;
    assign dirty = (st == ST_UD) || (st == ST_SD);

    always_comb begin
        issue = 1'b0;
        kind  = RQ_WB_FULL;
        if (home) begin
            if (dirty) begin
                issue = 1'b1;
                kind  = RQ_MEM_WRITE;
            end
        end else begin
            unique case (st)
                ST_UD, ST_SD: begin
                    issue = 1'b1;
                    kind  = sharers ? RQ_WCLEAN : RQ_WB_FULL;
                end
                ST_UC: begin issue = 1'b1; kind = RQ_WEVICT; end
                ST_SC: begin issue = 1'b1; kind = RQ_EVICT; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/coh_line_evict.sv
module coh_line_evict
    import coh_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int THRESH = 2,
    parameter int TOUT   = 5,
    localparam int LW    = $clog2(NLINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_allow_sd,
    input  logic          cfg_home,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [LW-1:0] cmd_line,
    input  logic [2:0]    cmd_fill_st,
    input  logic          cmd_sharers,
    input  logic [LW-1:0] q_line,
    output logic [2:0]    q_state,
    output logic          evict_valid,
    output logic [2:0]    evict_kind,
    output logic          evict_busy
);
    line_op_t  op;
    line_st_t  line_st [NLINES];
    line_st_t  sel_st;
    logic      sel_issue;
    evict_rq_t sel_kind;
    logic      is_evict;

    assign op       = line_op_t'(cmd_op);
    assign is_evict = cmd_valid && (op == OP_EVICT);

    for (genvar g = 0; g < NLINES; g++) begin : g_slot
        coh_line_slot #(.THRESH(THRESH), .TOUT(TOUT)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_allow_sd (cfg_allow_sd),
            .hit          (cmd_valid && (cmd_line == LW'(g))),
            .op           (op),
            .fill_st      (cmd_fill_st),
            .st           (line_st[g])
        );
    end

    assign sel_st  = line_st[cmd_line];
    assign q_state = line_st[q_line];

    coh_evict_sel u_sel (
        .st      (sel_st),
        .sharers (cmd_sharers),
        .home    (cfg_home),
        .issue   (sel_issue),
        .kind    (sel_kind)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evict_valid <= 1'b0;
            evict_kind  <= 3'd0;
            evict_busy  <= 1'b0;
        end else begin
            evict_busy  <= is_evict && (sel_st == ST_UDT);
            evict_valid <= is_evict && (sel_st != ST_UDT) && sel_issue;
            evict_kind  <= (is_evict && sel_issue) ? sel_kind : 3'd0;
        end
    end

    p_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evict_busy |-> !evict_valid);
    p_home_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_evict && cfg_home && sel_st != ST_UDT && sel_issue) |=> evict_kind == 3'd4);
    p_idle_evict_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_evict && sel_st == ST_I) |=> (!evict_valid && !evict_busy));
    p_evict_drops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (is_evict && sel_st != ST_UDT && q_line == cmd_line) |=> q_state == 3'd0);
endmodule

// File: tb/coh_line_evict_test.sv
module coh_line_evict_test;
    localparam int NL = 4, TH = 2, TO = 5;

    logic       clk = 0, rst_n = 0;
    logic       cfg_allow_sd = 1, cfg_home = 0;
    logic       cmd_valid = 0, cmd_sharers = 0;
    logic [2:0] cmd_op = 0, cmd_fill_st = 0;
    logic [1:0] cmd_line = 0, q_line = 0;
    logic [2:0] q_state, evict_kind;
    logic       evict_valid, evict_busy;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    coh_line_evict uut (.*);

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmd(int op, int ln, int fs, bit sh);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_line = 2'(ln);
        cmd_fill_st = 3'(fs); cmd_sharers = sh; q_line = 2'(ln);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    function automatic int exp_kind(int s, bit sh, bit home);
        bit dirty = (s == 3 || s == 4);
        if (home) return dirty ? 4 : -1;
        if (dirty) return sh ? 2 : 0;
        if (s == 2) return 1;
        if (s == 1) return 3;
        return -1;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            q_line = 2'(l); #1;
            chk("R1 reset state", q_state, 0);
        end
        chk("R1 reset outputs", {evict_valid, evict_busy}, 0);

        // R2 R3 R10 R11 R12: sweep fills x mode x sharers x home, then evict
        for (int sd = 0; sd < 2; sd++)
            for (int hm = 0; hm < 2; hm++)
                for (int fs = 0; fs < 8; fs++)
                    for (int sh = 0; sh < 2; sh++) begin
                        int es, ek;
                        cfg_allow_sd = sd[0]; cfg_home = hm[0];
                        cmd(3, 1, 0, 0);
                        cmd(1, 1, fs, 0);
                        es = (fs >= 1 && fs <= 4) ? fs : 0;
                        if (es == 3 && sd == 0) es = 4;
                        chk("R2/R3 fill state", q_state, es);
                        cmd(6, 1, 0, sh[0]);
                        ek = exp_kind(es, sh[0], hm[0]);
                        chk("R10/R11/R12 evict valid", evict_valid, ek >= 0);
                        if (ek >= 0) chk("R10/R11 evict kind", evict_kind, ek);
                        chk("R12 line dropped", q_state, 0);
                    end
        cfg_allow_sd = 1; cfg_home = 0;

        // R4 store/SC-ok and R5 snoop from each stable state
        for (int s = 0; s < 5; s++)
            for (int o = 0; o < 2; o++) begin
                cmd(3, 2, 0, 0);
                if (s > 0) cmd(1, 2, s, 0);
                cmd(o ? 5 : 2, 2, 0, 0);
                chk("R4 store result", q_state, s == 0 ? 0 : 4);
                cmd(3, 2, 0, 0);
                chk("R5 snoop to I", q_state, 0);
            end

        // R6 R8 R9: failures from I on line 3
        cmd(4, 3, 0, 0); chk("R6 first fail UD", q_state, 4);
        cmd(4, 3, 0, 0); chk("R6 fail in UD keeps", q_state, 4);
        cmd(3, 3, 0, 0);
        cmd(4, 3, 0, 0); chk("R6 over threshold UD_T", q_state, 5);
        cmd(6, 3, 0, 0);
        chk("R9 busy", evict_busy, 1);
        chk("R9 no request", evict_valid, 0);
        chk("R9 state kept", q_state, 5);
        cmd(3, 3, 0, 0);
        cmd(4, 3, 0, 0);
        begin
            int n = 0;
            chk("R8 entered UD_T", q_state, 5);
            while (q_state == 5 && n < 50) begin @(negedge clk); n++; end
            chk("R8 residency", n, TO);
            chk("R8 released to UD", q_state, 4);
        end

        // R7: SC ok clears count
        cmd(5, 3, 0, 0);
        cmd(3, 3, 0, 0);
        cmd(4, 3, 0, 0); chk("R7 cleared by SC ok", q_state, 4);
        for (int k = 0; k < 3; k++) cmd(4, 3, 0, 0);
        cmd(1, 3, 1, 0);
        cmd(3, 3, 0, 0);
        cmd(4, 3, 0, 0); chk("R7 cleared by shared fill", q_state, 4);
        cmd(4, 3, 0, 0); cmd(4, 3, 0, 0);
        cmd(3, 3, 0, 0);
        cmd(4, 3, 0, 0); chk("R6 count kept through I", q_state, 5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule